// File: doc/BRIEF.md
# Three-Position Promoting Write-Back Cache

This block is a very small, fully associative data cache. It sits between the load/store port of a simple processor and a memory port that is one word wide. It holds three entries in a fixed chain of positions, called the head, the middle and the tail. Each entry carries a valid flag, a dirty flag, the full word address used as its tag, and one data word.

Every new entry enters at the head. On a miss, the entries already held each move one position toward the tail, and the tail entry leaves the cache. On a hit, the entry that hit trades places with the head entry, and the other entries stay where they are. Stores allocate in the cache and mark the entry dirty. A dirty entry reaches memory only when it leaves the tail or when a flush runs.

The processor side uses a valid/ready request and a one-cycle response pulse. The memory side issues one single-word read or write at a time and holds it until the memory acknowledges it.

Top module: `promo_cache`

## Requirements
- R1: After reset all positions are invalid, `cpu_req_ready` is high within one cycle of reset release, and the first access to any address misses.
- R2: A read whose address matches a valid entry returns that entry's word with `cpu_rsp_valid` one cycle after acceptance. It starts no memory transaction.
- R3: A read miss issues one memory read (`mem_req_we`=0) for the requested address. It returns the fetched word and places it clean at the head. `cpu_req_ready` stays low from acceptance until the response.
- R4: A miss moves head to middle and middle to tail, and drops the tail entry. A hit swaps only the hit entry with the head entry, so an entry promoted from the tail survives the next miss.
- R5: A store that hits replaces the entry's word, marks it dirty and swaps it to the head. It starts no memory transaction, and a later read returns the stored word.
- R6: A store miss allocates a dirty head entry holding the store data. It does not write memory when it happens. If no write-back is needed, it responds one cycle after acceptance.
- R7: When an insertion displaces a valid dirty tail entry, that entry is written to memory (`mem_req_we`=1) before the new address is read. A clean tail entry is dropped with no memory traffic.
- R8: At most one memory request is outstanding. Its address, direction and data stay unchanged from issue until `mem_ack`.
- R9: A `flush_req` pulse while idle writes back every valid dirty entry in tail, middle, head order. It then invalidates all entries and pulses `flush_done`. Afterwards memory holds every stored value and all accesses miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request or flush |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load data, valid with the pulse |
| mem_req_valid | output | 1 | Memory request outstanding |
| mem_req_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | One-cycle completion of the outstanding request |
| mem_rdata | input | DATA_W | Fetched word, valid with `mem_ack` |
| flush_req | input | 1 | Start write-back and invalidate of all entries |
| flush_done | output | 1 | One-cycle pulse when the flush is complete |

## Verification
The bench aims at the cases where the swap-on-hit policy differs from true LRU. A tail entry is promoted by a hit and then a miss follows. A design that rotates the chain, or that shifts on hits, would then drop the wrong entry and miss on a later read that should hit. Dirty tail eviction on a read miss checks the order of memory operations: a design that fetched first, or that wrote back clean entries, would show the wrong transaction sequence. The bench also checks three further cases. Store hits followed by reads would expose a lost dirty flag or stale data. Flushes must write back in tail-first order. A final flush followed by a memory comparison would expose any write that was silently dropped.

// File: rtl/promo_cache_pkg.sv
package promo_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FETCH,
    ST_FL_SCAN,
    ST_FL_WB
  } state_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_HIT,
    OP_INSERT,
    OP_CLEAN,
    OP_CLEAR
  } op_e;

endpackage

// File: rtl/pc_tag_match.sv
module pc_tag_match #(
  parameter int N  = 3,
  parameter int AW = 16,
  parameter int IW = 2
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [AW-1:0]        addr,
  output logic [N-1:0]         match,
  output logic                 hit,
  output logic [IW-1:0]        hit_idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/pc_chain.sv
module pc_chain
  import promo_cache_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  op_e                  op,
  input  logic [IW-1:0]        op_idx,
  input  logic [AW-1:0]        new_tag,
  input  logic [DW-1:0]        new_data,
  input  logic                 new_dirty,
  output logic [N-1:0]         vld,
  output logic [N-1:0]         dirty,
  output logic [N-1:0][AW-1:0] tags,
  output logic [N-1:0][DW-1:0] datas
);

  // promoted entry for a hit: optionally updated by a store
  logic [AW-1:0] hit_tag;
  logic [DW-1:0] hit_data;
  logic          hit_dirty;

  always_comb begin
    hit_tag   = tags[op_idx];
    hit_data  = new_dirty ? new_data : datas[op_idx];
    hit_dirty = dirty[op_idx] | new_dirty;
  end

  for (genvar g = 0; g < N; g++) begin : g_pos
    logic          v_q;
    logic          d_q;
    logic [AW-1:0] t_q;
    logic [DW-1:0] x_q;

    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= 1'b0;
        end else begin
          case (op)
            OP_INSERT: begin
              v_q <= 1'b1;
              d_q <= new_dirty;
              t_q <= new_tag;
              x_q <= new_data;
            end
            OP_HIT: begin
              v_q <= 1'b1;
              d_q <= hit_dirty;
              t_q <= hit_tag;
              x_q <= hit_data;
            end
            OP_CLEAN: if (op_idx == '0) d_q <= 1'b0;
            OP_CLEAR: begin
              v_q <= 1'b0;
              d_q <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q <= 1'b0;
          d_q <= 1'b0;
        end else begin
          case (op)
            OP_INSERT: begin
              v_q <= vld[g-1];
              d_q <= dirty[g-1];
              t_q <= tags[g-1];
              x_q <= datas[g-1];
            end
            OP_HIT: if (op_idx == IW'(g)) begin
              v_q <= vld[0];
              d_q <= dirty[0];
              t_q <= tags[0];
              x_q <= datas[0];
            end
            OP_CLEAN: if (op_idx == IW'(g)) d_q <= 1'b0;
            OP_CLEAR: begin
              v_q <= 1'b0;
              d_q <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end

    assign vld[g]   = v_q;
    assign dirty[g] = d_q;
    assign tags[g]  = t_q;
    assign datas[g] = x_q;
  end

endmodule

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import promo_cache_pkg::*;
#(
  parameter int N  = 3,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpu_req_valid,
  input  logic                 cpu_req_we,
  input  logic [AW-1:0]        cpu_req_addr,
  input  logic [DW-1:0]        cpu_req_wdata,
  output logic                 cpu_req_ready,
  output logic                 cpu_rsp_valid,
  output logic [DW-1:0]        cpu_rsp_rdata,
  output logic                 mem_req_valid,
  output logic                 mem_req_we,
  output logic [AW-1:0]        mem_req_addr,
  output logic [DW-1:0]        mem_req_wdata,
  input  logic                 mem_ack,
  input  logic [DW-1:0]        mem_rdata,
  input  logic                 flush_req,
  output logic                 flush_done,
  input  logic                 hit,
  input  logic [IW-1:0]        hit_idx,
  input  logic [N-1:0]         vld,
  input  logic [N-1:0]         dirty,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [N-1:0][DW-1:0] datas,
  output op_e                  op,
  output logic [IW-1:0]        op_idx,
  output logic [AW-1:0]        new_tag,
  output logic [DW-1:0]        new_data,
  output logic                 new_dirty
);

  localparam logic [IW-1:0] TAIL = IW'(N - 1);

  state_e        state, state_n;
  logic          ready_q;
  logic          rsp_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;
  logic          mv_q, mwe_q;
  logic [AW-1:0] maddr_q;
  logic [DW-1:0] mdata_q;
  logic          pend_we;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_wdata;
  logic [IW-1:0] fl_idx, fl_idx_n;

  // decisions of the current cycle
  logic          accept;
  logic          need_wb;
  logic          rsp;
  logic [DW-1:0] rsp_data;
  logic          done;
  logic          ms_go;
  logic          ms_we;
  logic [AW-1:0] ms_addr;
  logic [DW-1:0] ms_data;
  logic          m_end;

  assign need_wb = vld[N-1] && dirty[N-1];
  assign accept  = (state == ST_IDLE) && ready_q && !flush_req && cpu_req_valid;

  always_comb begin
    state_n   = state;
    fl_idx_n  = fl_idx;
    op        = OP_NONE;
    op_idx    = hit_idx;
    new_tag   = pend_addr;
    new_data  = pend_wdata;
    new_dirty = 1'b0;
    rsp       = 1'b0;
    rsp_data  = rdata_q;
    done      = 1'b0;
    ms_go     = 1'b0;
    ms_we     = 1'b0;
    ms_addr   = pend_addr;
    ms_data   = '0;
    m_end     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (ready_q && flush_req) begin
          state_n  = ST_FL_SCAN;
          fl_idx_n = TAIL;
        end else if (accept) begin
          if (hit) begin
            op        = OP_HIT;
            new_dirty = cpu_req_we;
            new_data  = cpu_req_wdata;
            rsp       = 1'b1;
            rsp_data  = datas[hit_idx];
          end else if (need_wb) begin
            ms_go   = 1'b1;
            ms_we   = 1'b1;
            ms_addr = tags[N-1];
            ms_data = datas[N-1];
            state_n = ST_WB;
          end else if (!cpu_req_we) begin
            ms_go   = 1'b1;
            ms_addr = cpu_req_addr;
            state_n = ST_FETCH;
          end else begin
            op        = OP_INSERT;
            new_tag   = cpu_req_addr;
            new_data  = cpu_req_wdata;
            new_dirty = 1'b1;
            rsp       = 1'b1;
          end
        end
      end
      ST_WB: begin
        if (mem_ack) begin
          if (pend_we) begin
            op        = OP_INSERT;
            new_dirty = 1'b1;
            rsp       = 1'b1;
            m_end     = 1'b1;
            state_n   = ST_IDLE;
          end else begin
            ms_go   = 1'b1;
            ms_addr = pend_addr;
            state_n = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          op       = OP_INSERT;
          new_data = mem_rdata;
          rsp      = 1'b1;
          rsp_data = mem_rdata;
          m_end    = 1'b1;
          state_n  = ST_IDLE;
        end
      end
      ST_FL_SCAN: begin
        if (vld[fl_idx] && dirty[fl_idx]) begin
          ms_go   = 1'b1;
          ms_we   = 1'b1;
          ms_addr = tags[fl_idx];
          ms_data = datas[fl_idx];
          state_n = ST_FL_WB;
        end else if (fl_idx == '0) begin
          op      = OP_CLEAR;
          done    = 1'b1;
          state_n = ST_IDLE;
        end else begin
          fl_idx_n = fl_idx - 1'b1;
        end
      end
      ST_FL_WB: begin
        if (mem_ack) begin
          op      = OP_CLEAN;
          op_idx  = fl_idx;
          m_end   = 1'b1;
          state_n = ST_FL_SCAN;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ready_q <= 1'b0;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      mv_q    <= 1'b0;
      mwe_q   <= 1'b0;
      maddr_q <= '0;
      mdata_q <= '0;
      fl_idx  <= '0;
    end else begin
      state   <= state_n;
      ready_q <= (state_n == ST_IDLE);
      rsp_q   <= rsp;
      done_q  <= done;
      fl_idx  <= fl_idx_n;
      if (rsp) rdata_q <= rsp_data;
      if (ms_go) begin
        mv_q    <= 1'b1;
        mwe_q   <= ms_we;
        maddr_q <= ms_addr;
        mdata_q <= ms_data;
      end else if (m_end) begin
        mv_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pend_we    <= cpu_req_we;
      pend_addr  <= cpu_req_addr;
      pend_wdata <= cpu_req_wdata;
    end
  end

  assign cpu_req_ready = ready_q;
  assign cpu_rsp_valid = rsp_q;
  assign cpu_rsp_rdata = rdata_q;
  assign flush_done    = done_q;
  assign mem_req_valid = mv_q;
  assign mem_req_we    = mwe_q;
  assign mem_req_addr  = maddr_q;
  assign mem_req_wdata = mdata_q;

endmodule

// File: rtl/promo_cache.sv
module promo_cache
  import promo_cache_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int POSITIONS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              flush_req,
  output logic              flush_done
);

  localparam int IDX_W = (POSITIONS > 1) ? $clog2(POSITIONS) : 1;

  logic [POSITIONS-1:0]             ent_vld;
  logic [POSITIONS-1:0]             ent_dirty;
  logic [POSITIONS-1:0][ADDR_W-1:0] ent_tag;
  logic [POSITIONS-1:0][DATA_W-1:0] ent_data;
  logic [POSITIONS-1:0]             lookup_match;
  logic                             lookup_hit;
  logic [IDX_W-1:0]                 lookup_idx;
  op_e                              ch_op;
  logic [IDX_W-1:0]                 ch_idx;
  logic [ADDR_W-1:0]                ch_tag;
  logic [DATA_W-1:0]                ch_data;
  logic                             ch_dirty;

  pc_tag_match #(.N(POSITIONS), .AW(ADDR_W), .IW(IDX_W)) i_match (
    .vld     (ent_vld),
    .tags    (ent_tag),
    .addr    (cpu_req_addr),
    .match   (lookup_match),
    .hit     (lookup_hit),
    .hit_idx (lookup_idx)
  );

  pc_chain #(.N(POSITIONS), .AW(ADDR_W), .DW(DATA_W), .IW(IDX_W)) i_chain (
    .clk       (clk),
    .rst       (rst),
    .op        (ch_op),
    .op_idx    (ch_idx),
    .new_tag   (ch_tag),
    .new_data  (ch_data),
    .new_dirty (ch_dirty),
    .vld       (ent_vld),
    .dirty     (ent_dirty),
    .tags      (ent_tag),
    .datas     (ent_data)
  );

  pc_ctrl #(.N(POSITIONS), .AW(ADDR_W), .DW(DATA_W), .IW(IDX_W)) i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_we    (cpu_req_we),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .flush_req     (flush_req),
    .flush_done    (flush_done),
    .hit           (lookup_hit),
    .hit_idx       (lookup_idx),
    .vld           (ent_vld),
    .dirty         (ent_dirty),
    .tags          (ent_tag),
    .datas         (ent_data),
    .op            (ch_op),
    .op_idx        (ch_idx),
    .new_tag       (ch_tag),
    .new_data      (ch_data),
    .new_dirty     (ch_dirty)
  );

endmodule

// File: rtl/promo_cache_chk.sv
module promo_cache_chk #(
  parameter int N  = 3,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req_valid,
  input logic          cpu_req_ready,
  input logic          cpu_req_we,
  input logic          flush_req,
  input logic          flush_done,
  input logic          mem_req_valid,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_ack,
  input logic [N-1:0]  vld,
  input logic [N-1:0]  dirty,
  input logic [N-1:0]  match,
  input logic          hit
);

  logic acc;
  assign acc = cpu_req_valid && cpu_req_ready && !flush_req;

  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (vld == '0)) else $error("reset leaves entries valid"); // R1
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst) (acc && hit) |=> !mem_req_valid) else $error("hit started memory traffic"); // R2
  AST_MISS_BUSY: assert property (@(posedge clk) disable iff (rst) mem_req_valid |-> !cpu_req_ready) else $error("ready high during memory access"); // R3
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst) $onehot0(match)) else $error("address held twice"); // R4
  AST_STORE_MISS_QUIET: assert property (@(posedge clk) disable iff (rst) (acc && !hit && cpu_req_we && !(vld[N-1] && dirty[N-1])) |=> !mem_req_valid) else $error("store miss touched memory"); // R6
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst) (mem_req_valid && !mem_ack) |=> (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata))) else $error("memory request changed before ack"); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst) flush_done |-> (vld == '0)) else $error("flush left valid entries"); // R9

endmodule

bind promo_cache promo_cache_chk #(.N(POSITIONS), .AW(ADDR_W), .DW(DATA_W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .cpu_req_valid (cpu_req_valid),
  .cpu_req_ready (cpu_req_ready),
  .cpu_req_we    (cpu_req_we),
  .flush_req     (flush_req),
  .flush_done    (flush_done),
  .mem_req_valid (mem_req_valid),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_ack       (mem_ack),
  .vld           (ent_vld),
  .dirty         (ent_dirty),
  .match         (lookup_match),
  .hit           (lookup_hit)
);

// File: tb/test_promo_cache.sv
`timescale 1ns/1ps
module test_promo_cache;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NP = 3;
  localparam int LOGSZ = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_ready;
  logic          cpu_req_we = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          mem_req_valid;
  logic          mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          flush_req = 1'b0;
  logic          flush_done;

  int total = 0;
  int bad = 0;
  int mem_lat = 1;
  int lat_cnt = 0;
  int cycles = 0;

  logic [DW-1:0] mem   [0:255];
  logic [DW-1:0] truth [0:255];
  logic          lg_we [0:LOGSZ-1];
  logic [AW-1:0] lg_a  [0:LOGSZ-1];
  logic [DW-1:0] lg_d  [0:LOGSZ-1];
  int            lg_n = 0;

  // reference chain, index 0 = head
  logic          mv [NP];
  logic          mdt[NP];
  logic [AW-1:0] mt [NP];
  logic [DW-1:0] md [NP];

  promo_cache #(.ADDR_W(AW), .DATA_W(DW), .POSITIONS(NP)) i_promo_cache (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .flush_req(flush_req), .flush_done(flush_done)
  );

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] init_word(input int a);
    return 32'h5A00_0000 ^ (a * 32'h0001_0307);
  endfunction

  // memory responder
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      lat_cnt <= 0;
    end else if (mem_req_valid && !mem_ack) begin
      if (lat_cnt >= mem_lat) begin
        lat_cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_req_we) mem[mem_req_addr[7:0]] <= mem_req_wdata;
        else mem_rdata <= mem[mem_req_addr[7:0]];
        lg_we[lg_n % LOGSZ] <= mem_req_we;
        lg_a[lg_n % LOGSZ]  <= mem_req_addr;
        lg_d[lg_n % LOGSZ]  <= mem_req_wdata;
        lg_n <= lg_n + 1;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compares the memory log since 'start' against an expected list
  task automatic check_log(input int start, input int n, input logic ew[4], input logic [AW-1:0] ea[4],
                           input logic [DW-1:0] ed[4], input string req);
    check((lg_n - start) == n, {req, " txn count"}, DW'(lg_n - start), DW'(n));
    for (int k = 0; k < n && k < (lg_n - start); k++) begin
      int p = (start + k) % LOGSZ;
      check(lg_we[p] == ew[k], {req, " txn dir"}, DW'(lg_we[p]), DW'(ew[k]));
      check(lg_a[p] == ea[k], {req, " txn addr"}, DW'(lg_a[p]), DW'(ea[k]));
      if (ew[k]) check(lg_d[p] == ed[k], {req, " txn data"}, lg_d[p], ed[k]);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
    int            hi = -1;
    int            n = 0;
    int            start;
    int            cyc;
    bit            busy_ok = 1'b1;
    logic          ew[4];
    logic [AW-1:0] ea[4];
    logic [DW-1:0] ed[4];
    logic [DW-1:0] exp_rd;
    string         req;
    for (int k = 0; k < 4; k++) begin ew[k] = 1'b0; ea[k] = '0; ed[k] = '0; end
    for (int i = 0; i < NP; i++) if (mv[i] && mt[i] == a) hi = i;
    if (hi >= 0) begin
      req = we ? "R5" : "R2";
      if (we) begin md[hi] = wd; mdt[hi] = 1'b1; truth[a[7:0]] = wd; end
      exp_rd = md[hi];
      if (hi != 0) begin
        logic tv, tdt; logic [AW-1:0] tt; logic [DW-1:0] tx;
        tv = mv[0]; tdt = mdt[0]; tt = mt[0]; tx = md[0];
        mv[0] = mv[hi]; mdt[0] = mdt[hi]; mt[0] = mt[hi]; md[0] = md[hi];
        mv[hi] = tv; mdt[hi] = tdt; mt[hi] = tt; md[hi] = tx;
      end
    end else begin
      req = we ? "R6" : "R3";
      if (mv[NP-1] && mdt[NP-1]) begin
        ew[n] = 1'b1; ea[n] = mt[NP-1]; ed[n] = md[NP-1]; n++;
        req = "R7";
      end
      if (!we) begin ew[n] = 1'b0; ea[n] = a; n++; end
      exp_rd = truth[a[7:0]];
      for (int i = NP - 1; i > 0; i--) begin
        mv[i] = mv[i-1]; mdt[i] = mdt[i-1]; mt[i] = mt[i-1]; md[i] = md[i-1];
      end
      mv[0] = 1'b1; mdt[0] = we; mt[0] = a; md[0] = we ? wd : exp_rd;
      if (we) truth[a[7:0]] = wd;
    end
    if (tag != "") req = tag;
    start = lg_n;
    while (!cpu_req_ready) @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    cyc = 1;
    while (!cpu_rsp_valid) begin
      if (cpu_req_ready) busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (!we) check(cpu_rsp_rdata == exp_rd, {req, " read data"}, cpu_rsp_rdata, exp_rd);
    if (n == 0) check(cyc == 1, {req, " response latency"}, DW'(cyc), 32'd1);
    else check(busy_ok, {req, " ready low while busy"}, DW'(busy_ok), 32'd1);
    check_log(start, n, ew, ea, ed, req);
  endtask

  task automatic do_flush(input string req);
    int            n = 0;
    int            start;
    logic          ew[4];
    logic [AW-1:0] ea[4];
    logic [DW-1:0] ed[4];
    for (int k = 0; k < 4; k++) begin ew[k] = 1'b0; ea[k] = '0; ed[k] = '0; end
    for (int i = NP - 1; i >= 0; i--) begin
      if (mv[i] && mdt[i]) begin ew[n] = 1'b1; ea[n] = mt[i]; ed[n] = md[i]; n++; end
    end
    for (int i = 0; i < NP; i++) begin mv[i] = 1'b0; mdt[i] = 1'b0; end
    start = lg_n;
    while (!cpu_req_ready) @(negedge clk);
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    while (!flush_done) @(negedge clk);
    check_log(start, n, ew, ea, ed, req);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 256; a++) begin
      mem[a] = init_word(a);
      truth[a] = init_word(a);
    end
    for (int i = 0; i < NP; i++) begin mv[i] = 1'b0; mdt[i] = 1'b0; mt[i] = '0; md[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(cpu_req_ready == 1'b1, "R1 ready after reset", DW'(cpu_req_ready), 32'd1);
    check(cpu_rsp_valid == 1'b0, "R1 no response after reset", DW'(cpu_rsp_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R1 no memory request after reset", DW'(mem_req_valid), 32'd0);
    check(flush_done == 1'b0, "R1 no flush done after reset", DW'(flush_done), 32'd0);
    cpu_op(1'b0, 16'd0, '0, "R1");          // first access misses
    cpu_op(1'b0, 16'd0, '0, "");            // hit
    // R4 promotion order: chain 2,1,0 ; hit 0 at tail -> 0,1,2 ; miss 3 drops 2
    cpu_op(1'b0, 16'd1, '0, "R4");
    cpu_op(1'b0, 16'd2, '0, "R4");
    cpu_op(1'b0, 16'd0, '0, "R4");
    cpu_op(1'b0, 16'd3, '0, "R4");
    cpu_op(1'b0, 16'd0, '0, "R4");          // still present after promotion
    cpu_op(1'b0, 16'd2, '0, "R4");          // was dropped
    // R6 store miss, R7 dirty eviction before fetch
    cpu_op(1'b1, 16'd5, 32'hDEAD_0005, "");
    cpu_op(1'b0, 16'd6, '0, "R7");
    cpu_op(1'b0, 16'd7, '0, "R7");
    cpu_op(1'b0, 16'd8, '0, "R7");
    // R5 store hit then read back
    cpu_op(1'b1, 16'd8, 32'hBEEF_0008, "");
    cpu_op(1'b0, 16'd8, '0, "R5");
    cpu_op(1'b1, 16'd6, 32'hCAFE_0006, "");
    // R9 flush order and invalidation
    do_flush("R9");
    cpu_op(1'b0, 16'd8, '0, "R9");
    cpu_op(1'b0, 16'd6, '0, "R9");
    mem_lat = 0;
    cpu_op(1'b1, 16'd9, 32'h1234_5678, "R8");
    // random traffic
    for (int it = 0; it < 600; it++) begin
      int r = int'($urandom_range(99, 0));
      mem_lat = int'($urandom_range(3, 0));
      if (r < 4) do_flush("R9");
      else cpu_op(logic'(r % 2), AW'($urandom_range(9, 0)), $urandom, "");
    end
    do_flush("R9");
    for (int a = 0; a < 16; a++) begin
      check(mem[a] == truth[a], "R9 memory coherent after flush", mem[a], truth[a]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule